// File: doc/BRIEF.md
# Serial Wire Debug Transaction Engine

This block runs one complete read or write access on a two-wire serial debug link, acting as the host. A caller presents a 4-bit request and, for writes, a 32-bit word, then pulses `start`. The engine sends the 8-bit request header and releases the data line for the turnaround. It then samples the 3-bit acknowledge from the target and runs the matching data phase. Last, it clocks the configured idle cycles. When it finishes, it returns a 4-bit response code and, for reads, the captured word.

The engine owns the clock and data pins directly: `swclk`, the data output `swdio_o`, the output enable `swdio_oe`, and the input `swdio_i`. One bit slot lasts `2*HALF_CYC` system clocks. The clock is low for the first half of the slot and high for the second half. Outputs change only at the start of a slot. The input is sampled at the last system clock of the slot.

Besides the normal paths, the engine recovers from the target's wait and fault replies, with an optional dummy data phase. It also recovers from a malformed acknowledge by clocking enough released cycles to let the target finish whatever it believes it is doing. Line resets and retry policy belong to the caller.

Top module: `swd_xfer_ctrl`

## Requirements
- R1: The header goes out over 8 slots with the line driven, in this bit order: 1, then `req[0]`, `req[1]`, `req[2]`, `req[3]`, then the even parity of `req[3:0]`, then 0, then 1. `swdio_o` and `swdio_oe` change only while `swclk` is low.
- R2: After the header, the line is released for `trn_cfg+1` slots. The line stays released for 3 more slots while the acknowledge is sampled, first bit as bit 0. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. `req[1]` = 1 selects a read.
- R3: On an OK read, the engine samples 33 released slots: data bits 0 to 31, then a parity bit. It returns the data on `rdata`. If the parity bit differs from the even parity of the data, `rsp` becomes 4'b1000; otherwise `rsp` is {1'b0, ack}. After the data, the line stays released for `trn_cfg+1` more slots.
- R4: On an OK write, the engine releases the line for `trn_cfg+1` slots. It then drives `wdata` bits 0 to 31, followed by their even parity, over 33 slots.
- R5: After an OK data phase, which includes a read whose parity failed, the engine clocks `idle_cfg` slots with the line driven low. When `idle_cfg` = 0, no idle slot is clocked.
- R6: On WAIT or FAULT, the engine releases the line for `trn_cfg+1` slots. A read with `dp_on_err` = 1 adds 33 more released slots. No idle slots follow, and `rsp` = {1'b0, ack}.
- R7: On WAIT or FAULT for a write with `dp_on_err` = 1, the turnaround is followed by 33 slots driven low.
- R8: Any other acknowledge value makes the engine release the line for `trn_cfg+1+33` slots. `rsp` then returns the raw acknowledge as {1'b0, ack}.
- R9: Between transactions, and out of reset, `swclk` = 1, `swdio_oe` = 1 and `swdio_o` = 1. No clock pulse is produced beyond the slots listed above.
- R10: `start` is accepted only when `busy` = 0, and `busy` rises on the next clock. `done` is a single-cycle pulse that comes with `busy` falling. A `start` that arrives while busy has no effect on the transaction in flight and does not launch another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (taken when idle) |
| req | input | 4 | Request bits; bit 1 selects read |
| wdata | input | 32 | Word to write |
| trn_cfg | input | TRN_W | Turnaround length minus one |
| idle_cfg | input | IDLE_W | Idle slots after an OK transfer |
| dp_on_err | input | 1 | Run a dummy data phase on WAIT/FAULT |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rsp | output | 4 | {parity error, acknowledge} |
| rdata | output | 32 | Captured read word |
| swclk | output | 1 | Serial clock to target |
| swdio_o | output | 1 | Serial data out |
| swdio_oe | output | 1 | Serial data output enable |
| swdio_i | input | 1 | Serial data in |

## Verification
The bench builds the engine with `HALF_CYC` = 2, which gives four-clock slots and keeps every path short. It uses `IDLE_W` = 4, so the largest idle count of 15 can be exercised as well as zero. It keeps `TRN_W` = 2 so that turnarounds of one to four slots are all reachable. With these values, every acknowledge path, both parity outcomes and both settings of the dummy-phase flag fit inside a short run.

// File: rtl/swd_xfer_pkg.sv
package swd_xfer_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HDR,
      ST_TRNA,
      ST_ACK,
      ST_RDAT,
      ST_TRNR,
      ST_TRNW,
      ST_WDAT,
      ST_IDLC,
      ST_DRAIN,
      ST_WZERO
   } swd_st_e;

   localparam logic [2:0] ACK_OK    = 3'b001;
   localparam logic [2:0] ACK_WAIT  = 3'b010;
   localparam logic [2:0] ACK_FAULT = 3'b100;
   localparam logic [3:0] RSP_PERR  = 4'b1000;
   localparam int         REQ_RNW   = 1;
   localparam int         DATA_SLOTS = 33;

   // header word, bit 0 leaves first
   function automatic logic [7:0] swd_header(input logic [3:0] r);
      return {1'b1, 1'b0, ^r, r, 1'b1};
   endfunction

endpackage

// File: rtl/swd_tick_gen.sv
module swd_tick_gen #(
   parameter int HALF_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic swclk,
   output logic slot_end
);
   localparam int PER = 2 * HALF_CYC;
   localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (!run)                   cnt <= '0;
      else if (cnt == CW'(PER - 1))    cnt <= '0;
      else                             cnt <= cnt + 1'b1;
   end

   assign slot_end = run && (cnt == CW'(PER - 1));
   assign swclk    = !run || (cnt >= CW'(HALF_CYC));

   // a clock fall inside a transaction always follows the end of a slot
   AST_FALL_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $fell(swclk)) |-> $past(slot_end)) else $error("AST_FALL_AT_SLOT"); // R1

endmodule

// File: rtl/swd_slot_cnt.sv
module swd_slot_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         adv,
   input  logic [W-1:0] len,
   output logic [W-1:0] idx,
   output logic         last
);
   generate
      if (W < 6) begin : g_bad_w
         $error("slot counter narrower than a data phase");
      end
   endgenerate

   assign last = (idx == len - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              idx <= '0;
      else if (clr)            idx <= '0;
      else if (adv && last)    idx <= '0;
      else if (adv)            idx <= idx + 1'b1;
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && last) |=> (idx == '0)) else $error("AST_IDX_IN_RANGE"); // R2

endmodule

// File: rtl/swd_xfer_ctrl.sv
module swd_xfer_ctrl
   import swd_xfer_pkg::*;
#(
   parameter int HALF_CYC = 4,
   parameter int IDLE_W   = 8,
   parameter int TRN_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        req,
   input  logic [31:0]       wdata,
   input  logic [TRN_W-1:0]  trn_cfg,
   input  logic [IDLE_W-1:0] idle_cfg,
   input  logic              dp_on_err,
   output logic              busy,
   output logic              done,
   output logic [3:0]        rsp,
   output logic [31:0]       rdata,
   output logic              swclk,
   output logic              swdio_o,
   output logic              swdio_oe,
   input  logic              swdio_i
);
   localparam int LONG_MAX = (1 << TRN_W) + DATA_SLOTS;
   localparam int LW       = $clog2(LONG_MAX + 1);
   localparam int CNT_W    = (IDLE_W > LW) ? IDLE_W : LW;

   generate
      if (TRN_W < 1 || IDLE_W < 1) begin : g_bad_cfg
         $error("TRN_W and IDLE_W must be at least 1");
      end
   endgenerate

   swd_st_e            st;
   logic [CNT_W-1:0]   len, idx, trn_q, idle_q;
   logic [3:0]         req_q;
   logic [7:0]         hdr_q;
   logic [31:0]        wd_q, sh;
   logic               dp_q, wz_q, last, slot_end;
   logic [2:0]         ack_now;
   logic               rd_q;

   assign busy    = (st != ST_IDLE);
   assign rd_q    = req_q[REQ_RNW];
   assign ack_now = {swdio_i, sh[31], sh[30]};

   swd_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .swclk(swclk), .slot_end(slot_end)
   );

   swd_slot_cnt #(.W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .clr(!busy), .adv(slot_end),
      .len(len), .idx(idx), .last(last)
   );

   // line drive per state
   always_comb begin
      swdio_oe = 1'b0;
      swdio_o  = 1'b1;
      unique case (st)
         ST_IDLE: begin swdio_oe = 1'b1; swdio_o = 1'b1; end
         ST_HDR:  begin swdio_oe = 1'b1; swdio_o = hdr_q[idx[2:0]]; end
         ST_WDAT: begin
            swdio_oe = 1'b1;
            swdio_o  = (idx == CNT_W'(32)) ? ^wd_q : wd_q[idx[4:0]];
         end
         ST_IDLC, ST_WZERO: begin swdio_oe = 1'b1; swdio_o = 1'b0; end
         default: begin swdio_oe = 1'b0; swdio_o = 1'b1; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         len    <= CNT_W'(8);
         trn_q  <= '0;
         idle_q <= '0;
         req_q  <= '0;
         hdr_q  <= '0;
         wd_q   <= '0;
         dp_q   <= 1'b0;
         wz_q   <= 1'b0;
         sh     <= '0;
         rsp    <= '0;
         rdata  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (start) begin
               req_q  <= req;
               hdr_q  <= swd_header(req);
               wd_q   <= wdata;
               trn_q  <= CNT_W'(trn_cfg) + 1'b1;
               idle_q <= CNT_W'(idle_cfg);
               dp_q   <= dp_on_err;
               wz_q   <= 1'b0;
               len    <= CNT_W'(8);
               st     <= ST_HDR;
            end
         end else if (slot_end) begin
            if (st == ST_ACK || (st == ST_RDAT && !last))
               sh <= {swdio_i, sh[31:1]};
            if (last) begin
               unique case (st)
                  ST_HDR:  begin st <= ST_TRNA; len <= trn_q; end
                  ST_TRNA: begin st <= ST_ACK;  len <= CNT_W'(3); end
                  ST_ACK: begin
                     rsp <= {1'b0, ack_now};
                     if (ack_now == ACK_OK) begin
                        st  <= rd_q ? ST_RDAT : ST_TRNW;
                        len <= rd_q ? CNT_W'(DATA_SLOTS) : trn_q;
                     end else if (ack_now == ACK_WAIT || ack_now == ACK_FAULT) begin
                        st   <= ST_DRAIN;
                        len  <= (dp_q && rd_q) ? trn_q + CNT_W'(DATA_SLOTS) : trn_q;
                        wz_q <= dp_q && !rd_q;
                     end else begin
                        st  <= ST_DRAIN;
                        len <= trn_q + CNT_W'(DATA_SLOTS);
                     end
                  end
                  ST_RDAT: begin
                     rdata <= sh;
                     if ((^sh) != swdio_i) rsp <= RSP_PERR;
                     st  <= ST_TRNR;
                     len <= trn_q;
                  end
                  ST_TRNR, ST_WDAT: begin
                     if (idle_q == '0) begin st <= ST_IDLE; done <= 1'b1; end
                     else begin st <= ST_IDLC; len <= idle_q; end
                  end
                  ST_TRNW: begin st <= ST_WDAT; len <= CNT_W'(DATA_SLOTS); end
                  ST_DRAIN: begin
                     if (wz_q) begin st <= ST_WZERO; len <= CNT_W'(DATA_SLOTS); end
                     else begin st <= ST_IDLE; done <= 1'b1; end
                  end
                  default: begin st <= ST_IDLE; done <= 1'b1; end
               endcase
            end
         end
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("AST_DONE_SINGLE"); // R10
   AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done) else $error("AST_DONE_WITH_END"); // R10
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(req_q)) else $error("AST_START_IGNORED"); // R10
   AST_END_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (swclk && swdio_oe && swdio_o)) else $error("AST_END_LINE_HIGH"); // R9
   AST_LINE_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && swclk && $past(swclk)) |-> ($stable(swdio_oe) && $stable(swdio_o))) else $error("AST_LINE_STILL_HIGH"); // R1
   AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_end && st == ST_TRNA && last) |=> !swdio_oe) else $error("AST_ACK_RELEASED"); // R2

endmodule

// File: tb/tb_swd_xfer_ctrl.sv
module tb_swd_xfer_ctrl;
   localparam int HALF = 2;
   localparam int IW   = 4;
   localparam int TW   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0] req = '0;
   logic [31:0] wdata = '0;
   logic [TW-1:0] trn_cfg = '0;
   logic [IW-1:0] idle_cfg = '0;
   logic dp_on_err = 1'b0;
   logic swdio_i = 1'b1;
   logic busy, done, swclk, swdio_o, swdio_oe;
   logic [3:0] rsp;
   logic [31:0] rdata;

   always #4 clk = ~clk;   // 125 MHz

   swd_xfer_ctrl #(.HALF_CYC(HALF), .IDLE_W(IW), .TRN_W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wdata),
      .trn_cfg(trn_cfg), .idle_cfg(idle_cfg), .dp_on_err(dp_on_err),
      .busy(busy), .done(done), .rsp(rsp), .rdata(rdata),
      .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
   );

   int checks = 0;
   int fails  = 0;
   bit eoe[$];
   bit eout[$];
   bit din[$];
   string etag[$];
   int slot = 0;
   logic prev_clk = 1'b1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put(input bit oe, input bit o, input bit i, input string tag);
      eoe.push_back(oe); eout.push_back(o); din.push_back(i); etag.push_back(tag);
   endtask

   // target model and slot-level comparison against the reference queues
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_clk && !swclk)
            swdio_i <= (slot < din.size()) ? din[slot] : 1'b1;
         if (!prev_clk && swclk) begin
            if (slot < eoe.size()) begin
               chk(swdio_oe == eoe[slot], {etag[slot], " oe"}, swdio_oe, eoe[slot]);
               if (eoe[slot]) chk(swdio_o == eout[slot], {etag[slot], " data"}, swdio_o, eout[slot]);
            end else
               chk(1'b0, "R9 extra clock pulse", slot, eoe.size());
            slot++;
         end
      end
      prev_clk <= swclk;
   end

   task automatic xfer(input logic [3:0] rq, input logic [31:0] wd, input int trn,
                       input int idl, input bit dp, input logic [2:0] ack,
                       input logic [31:0] rd, input bit flip, input bit poke);
      int t;
      bit rnw;
      bit ok;
      bit waitfault;
      int wcnt;
      logic [3:0] exp_rsp;
      eoe.delete(); eout.delete(); din.delete(); etag.delete();
      slot = 0;
      t = trn + 1;
      rnw = rq[1];
      ok = (ack == 3'b001);
      waitfault = (ack == 3'b010) || (ack == 3'b100);
      // header
      put(1, 1, 1, "R1");
      for (int k = 0; k < 4; k++) put(1, rq[k], 1, "R1");
      put(1, ^rq, 1, "R1");
      put(1, 0, 1, "R1");
      put(1, 1, 1, "R1");
      for (int k = 0; k < t; k++) put(0, 1, 1, "R2");
      for (int k = 0; k < 3; k++) put(0, 1, ack[k], "R2");
      exp_rsp = {1'b0, ack};
      if (ok && rnw) begin
         for (int k = 0; k < 32; k++) put(0, 1, rd[k], "R3");
         put(0, 1, (^rd) ^ flip, "R3");
         for (int k = 0; k < t; k++) put(0, 1, 1, "R3");
         for (int k = 0; k < idl; k++) put(1, 0, 1, "R5");
         if (flip) exp_rsp = 4'b1000;
      end else if (ok) begin
         for (int k = 0; k < t; k++) put(0, 1, 1, "R4");
         for (int k = 0; k < 32; k++) put(1, wd[k], 1, "R4");
         put(1, ^wd, 1, "R4");
         for (int k = 0; k < idl; k++) put(1, 0, 1, "R5");
      end else if (waitfault) begin
         for (int k = 0; k < t; k++) put(0, 1, 1, "R6");
         if (dp && rnw) for (int k = 0; k < 33; k++) put(0, 1, 1, "R6");
         if (dp && !rnw) for (int k = 0; k < 33; k++) put(1, 0, 1, "R7");
      end else begin
         for (int k = 0; k < t + 33; k++) put(0, 1, 1, "R8");
      end

      @(negedge clk);
      req = rq; wdata = wd; trn_cfg = TW'(trn); idle_cfg = IW'(idl); dp_on_err = dp;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R10 busy after start", busy, 1);
      if (poke) begin
         repeat (30) @(negedge clk);
         req = ~rq; wdata = ~wd; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wcnt = 0;
      while (!done && wcnt < 20000) begin
         @(negedge clk);
         wcnt++;
      end
      chk(done == 1'b1, "R10 done pulse seen", done, 1);
      chk(busy == 1'b0, "R10 busy low with done", busy, 0);
      chk(rsp == exp_rsp, "R3 R6 R8 response code", rsp, exp_rsp);
      if (ok && rnw && !flip) chk(rdata == rd, "R3 read data", rdata, rd);
      @(negedge clk);
      chk(done == 1'b0, "R10 done lasts one cycle", done, 0);
      repeat (12) @(negedge clk);
      chk(slot == eoe.size(), "R9 slot count", slot, eoe.size());
      chk(swclk && swdio_oe && swdio_o, "R9 line parked high",
          {swclk, swdio_oe, swdio_o}, 3'b111);
      chk(busy == 1'b0, "R10 no second launch", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(swclk && swdio_oe && swdio_o && !busy && !done, "R9 reset state",
          {swclk, swdio_oe, swdio_o, busy, done}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // OK write, short turnaround, two idle slots
      xfer(4'b0101, 32'hA5C3_0F71, 0, 2, 0, 3'b001, 32'h0, 0, 0);
      // OK read, good parity, no idle
      xfer(4'b1010, 32'h0, 1, 0, 0, 3'b001, 32'h1234_8ACF, 0, 0);
      // OK read, bad parity, maximum idle
      xfer(4'b0011, 32'h0, 3, 15, 0, 3'b001, 32'hFFFF_0001, 1, 0);
      // WAIT read with dummy phase
      xfer(4'b0110, 32'h0, 2, 5, 1, 3'b010, 32'h0, 0, 0);
      // FAULT read without dummy phase
      xfer(4'b1110, 32'h0, 0, 5, 0, 3'b100, 32'h0, 0, 0);
      // WAIT write with dummy phase
      xfer(4'b0001, 32'hDEAD_BEEF, 1, 5, 1, 3'b010, 32'h0, 0, 0);
      // FAULT write without dummy phase
      xfer(4'b1001, 32'h0BAD_F00D, 3, 5, 0, 3'b100, 32'h0, 0, 0);
      // malformed acknowledges
      xfer(4'b0010, 32'h0, 1, 5, 1, 3'b111, 32'h0, 0, 0);
      xfer(4'b1000, 32'h0, 0, 5, 0, 3'b000, 32'h0, 0, 0);
      // start pulsed while busy
      xfer(4'b0100, 32'h8000_0001, 0, 1, 0, 3'b001, 32'h0, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule